// File: doc/BRIEF.md
# Up-Counting Timer with Update Control

This block is a general-purpose up-counting timer that runs on a single kernel clock. An active prescaler divides the clock into counter ticks. On each tick the counter steps from zero up to an active reload limit. On the tick that finds it at or above that limit, it wraps to zero and reports an overflow. Overflow, or a software update strobe, can raise an update event. The update event moves the buffered prescaler and reload values into their active copies, sets an update flag and, in single-shot mode, stops the timer.

Software reaches the timer through a simple write/read register port. The port has one write strobe with its own address and data. A separate read address returns data combinationally. A control register governs the update event. It can suppress the event, limit its source to overflow, select whether the reload value is buffered, and mirror the update flag into the top bit of the counter read. A separate output carries a divided sampling-clock enable, dividing the kernel clock by 1, 2 or 4.

Top module: `upcount_timer`

## Requirements
- R1: The register addresses are: 0 control, 1 prescaler, 2 reload, 3 counter, 4 status (update flag in bit 0), and 5 event strobe (write-only, reads 0). The control fields are: bit 0 run, bit 1 update suppress, bit 2 overflow-only source, bit 3 single-shot, bit 4 reload buffering, bits 6:5 sampling division, and bit 7 flag mirror. After reset every register reads 0 and the flag output is 0.
- R2: While run is 0 the counter keeps its value. While run is 1 the counter increments by one on each prescaler tick.
- R3: The counter counts from 0 up to the active reload value. On the next tick it returns to 0 and signals overflow. Every update event that is generated sets the update flag. Writing the status register with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag unchanged.
- R4: A tick occurs every (active prescaler + 1) kernel cycles. A prescaler write reaches the active copy only at an update event.
- R5: While update suppress is 1, neither overflow nor the strobe produces an update event. The flag is not set, and the active prescaler and reload copies keep their values.
- R6: Writing 1 to bit 0 of the event strobe register always clears the counter and the prescaler's cycle count, even while update suppress is 1.
- R7: When overflow-only is 0, both overflow and the strobe produce an update event. When it is 1, only overflow does.
- R8: In single-shot mode an update event clears the run bit, and the counter stays where it stopped. Outside single-shot mode, counting continues through update events.
- R9: When reload buffering is 0, a reload write takes effect on the next cycle. When it is 1, the written value waits and is copied to the active limit at an update event. Reading the reload register returns the last value written.
- R10: The sampling enable is high every cycle for division codes 0 and 3, one cycle in 2 for code 1, and one cycle in 4 for code 2.
- R11: A counter read returns the count zero-extended. Bit 31 carries the update flag when flag mirror is 1, and is 0 otherwise.
- R12: A write to the counter register loads the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| upd_flag | output | 1 | Update-interrupt flag |
| smp_en | output | 1 | Divided sampling-clock enable |

## Verification
The bench writes a new prescaler value without an update event and checks that the count rate stays the same; a design that made prescaler writes immediate would count slower too early. With update suppress set, it fires the strobe in the middle of a prescaler period and measures when the next tick arrives; a design that cleared only the counter would tick too soon. It runs a buffered reload that is smaller than the current limit and expects the old limit to hold until the wrap, then the new one; an unbuffered shortcut would wrap early. The bench also covers single-shot stopping, overflow-only source rejection of the strobe, all four sampling-division codes including the reserved one, and the flag clear rule that ignores a written 1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_AW = 3;
    localparam int BUS_W  = 32;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL   = 3'd0,
        A_PSC    = 3'd1,
        A_RELOAD = 3'd2,
        A_COUNT  = 3'd3,
        A_STAT   = 3'd4,
        A_EVGEN  = 3'd5
    } reg_addr_e;

    // packed MSB first: mirror is bit 7, run is bit 0
    typedef struct packed {
        logic       mirror;
        logic [1:0] smpdiv;
        logic       rl_buf;
        logic       single;
        logic       ovf_only;
        logic       upd_sup;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic ug;
        logic ovf;
        logic uev;
    } evt_t;

    // low divider bits that must all be set for an enable pulse
    function automatic logic [1:0] smp_mask(input logic [1:0] code);
        case (code)
            2'd1:    return 2'b01;
            2'd2:    return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic update_fires(input ctrl_t c, input logic ovf, input logic ug);
        return !c.upd_sup && (ovf || (ug && !c.ovf_only));
    endfunction

endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic                uev,
    output ctrl_t               ctrl,
    output logic [PSC_W-1:0]    psc_pre,
    output logic [PSC_W-1:0]    psc_act,
    output logic [CNT_W-1:0]    arr_pre,
    output logic [CNT_W-1:0]    arr_act,
    output logic                flag
);

    logic wr_ctrl, wr_psc, wr_arr, wr_stat;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == A_CTRL);
        wr_psc  = wr_en && (wr_addr == A_PSC);
        wr_arr  = wr_en && (wr_addr == A_RELOAD);
        wr_stat = wr_en && (wr_addr == A_STAT);
    end

    // control word; single-shot stop is cleared by hardware
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end else if (uev && ctrl.single) begin
            ctrl.run <= 1'b0;
        end
    end

    // prescaler: always buffered
    always_ff @(posedge clk) begin
        if (rst) begin
            psc_pre <= '0;
            psc_act <= '0;
        end else begin
            if (wr_psc) psc_pre <= wr_data[PSC_W-1:0];
            if (uev)    psc_act <= psc_pre;
        end
    end

    // reload: buffered or direct as control selects
    always_ff @(posedge clk) begin
        if (rst) begin
            arr_pre <= '0;
            arr_act <= '0;
        end else begin
            if (uev && ctrl.rl_buf) arr_act <= arr_pre;
            if (wr_arr) begin
                arr_pre <= wr_data[CNT_W-1:0];
                if (!ctrl.rl_buf) arr_act <= wr_data[CNT_W-1:0];
            end
        end
    end

    // update flag: set wins over a clearing write
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (uev) begin
            flag <= 1'b1;
        end else if (wr_stat && !wr_data[0]) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] psc_act,
    input  logic             clr,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt;

    assign tick = run && (pcnt >= psc_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] arr_act,
    input  logic             reinit,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    // at or above the limit counts as the end, so a value loaded past it wraps at once
    assign ovf = tick && (cnt >= arr_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (reinit) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (ovf) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_smpdiv.sv
module tmr_smpdiv
    import tmr_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] code,
    output logic       en
);

    logic [DIV_W-1:0] dcnt;
    logic [1:0]       mask;

    always_comb begin
        mask = smp_mask(code);
        en   = ((dcnt[1:0] & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) dcnt <= '0;
        else     dcnt <= dcnt + 1'b1;
    end

endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              upd_flag,
    output logic              smp_en
);

    localparam int LOW_W = BUS_W - 1;

    ctrl_t            ctrl_q;
    logic [PSC_W-1:0] psc_pre, psc_act;
    logic [CNT_W-1:0] arr_pre, arr_act, cnt_q;
    logic             flag_q, tick, cnt_wr, ctrl_wr;
    evt_t             ev;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        cnt_wr  = wr_en && (wr_addr == A_COUNT);
        ev.ug   = wr_en && (wr_addr == A_EVGEN) && wr_data[0];
        ev.uev  = update_fires(ctrl_q, ev.ovf, ev.ug);
    end

    tmr_ctrl_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .uev     (ev.uev),
        .ctrl    (ctrl_q),
        .psc_pre (psc_pre),
        .psc_act (psc_act),
        .arr_pre (arr_pre),
        .arr_act (arr_act),
        .flag    (flag_q)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .psc_act (psc_act),
        .clr     (ev.ug || ev.uev),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .arr_act  (arr_act),
        .reinit   (ev.ug),
        .load     (cnt_wr),
        .load_val (wr_data[CNT_W-1:0]),
        .cnt      (cnt_q),
        .ovf      (ev.ovf)
    );

    tmr_smpdiv #(.DIV_W(2)) u_div (
        .clk  (clk),
        .rst  (rst),
        .code (ctrl_q.smpdiv),
        .en   (smp_en)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data = BUS_W'(ctrl_q);
            A_PSC:    rd_data = BUS_W'(psc_pre);
            A_RELOAD: rd_data = BUS_W'(arr_pre);
            A_COUNT:  rd_data = {ctrl_q.mirror & flag_q, LOW_W'(cnt_q)};
            A_STAT:   rd_data = BUS_W'(flag_q);
            default:  rd_data = '0;
        endcase
    end

    assign upd_flag = flag_q;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input ctrl_t            ctrl,
    input logic             ctrl_wr,
    input logic             cnt_wr,
    input evt_t             ev,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] arr_act,
    input logic [PSC_W-1:0] psc_act,
    input logic             flag
);

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !ev.ug && !cnt_wr) |=> $stable(cnt)); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == arr_act && !ev.ug && !cnt_wr) |=> (cnt == '0)); // R3

    AST_SUP_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl.upd_sup && !flag) |=> !flag); // R5

    AST_SUP_PSC_KEEP: assert property (@(posedge clk) disable iff (rst)
        ctrl.upd_sup |=> $stable(psc_act)); // R5

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ev.ug |=> (cnt == '0)); // R6

    AST_OVF_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ovf_only && ev.ug && !ev.ovf && !flag) |=> !flag); // R7

    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (rst)
        (ev.uev && ctrl.single && !ctrl_wr) |=> !ctrl.run); // R8

endmodule

bind upcount_timer tmr_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl_q),
    .ctrl_wr (ctrl_wr),
    .cnt_wr  (cnt_wr),
    .ev      (ev),
    .tick    (tick),
    .cnt     (cnt_q),
    .arr_act (arr_act),
    .psc_act (psc_act),
    .flag    (flag_q)
);

// File: tb/test_upcount_timer.sv
module test_upcount_timer;

    localparam logic [31:0] C_RUN = 32'h01;
    localparam logic [31:0] C_SUP = 32'h02;
    localparam logic [31:0] C_OVO = 32'h04;
    localparam logic [31:0] C_ONE = 32'h08;
    localparam logic [31:0] C_BUF = 32'h10;
    localparam logic [31:0] C_MIR = 32'h80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        upd_flag, smp_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    upcount_timer i_upcount_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .upd_flag(upd_flag), .smp_en(smp_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_cnt(input string tag, input logic [31:0] exp);
        logic [31:0] d;
        rd(3'd3, d);
        chk(tag, d, exp);
    endtask

    // stop, load prescaler/reload, strobe an update, clear the flag
    task automatic setup(input logic [31:0] psc, input logic [31:0] arr);
        wr(3'd0, 32'h0);
        wr(3'd1, psc);
        wr(3'd2, arr);
        wr(3'd5, 32'h1);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", d, 32'h0);
        end
        chk("R1 reset flag", 32'(upd_flag), 32'h0);
    endtask

    task automatic t_count();
        setup(0, 100);
        wr(3'd0, C_RUN);
        wait_cyc(5);
        chk_cnt("R2 advance", 32'd5);
        wr(3'd0, 32'h0);
        wait_cyc(4);
        chk_cnt("R2 hold when stopped", 32'd6);
        wr(3'd3, 32'd7);
        chk_cnt("R12 counter load", 32'd7);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        setup(0, 3);
        wr(3'd0, C_RUN);
        wait_cyc(3);
        chk_cnt("R3 at limit", 32'd3);
        chk("R3 no flag before wrap", 32'(upd_flag), 32'h0);
        wait_cyc(1);
        chk_cnt("R3 wrap to zero", 32'd0);
        chk("R3 flag on overflow", 32'(upd_flag), 32'h1);
        wr(3'd4, 32'h1);
        chk("R3 write one keeps flag", 32'(upd_flag), 32'h1);
        wr(3'd4, 32'h0);
        rd(3'd4, d);
        chk("R3 write zero clears flag", d, 32'h0);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_psc();
        setup(0, 100);
        wr(3'd1, 32'd2);
        wr(3'd0, C_RUN);
        wait_cyc(3);
        chk_cnt("R4 preload not yet active", 32'd3);
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h1);
        wr(3'd4, 32'h0);
        wr(3'd0, C_RUN);
        wait_cyc(2);
        chk_cnt("R4 divide by 3 early", 32'd0);
        wait_cyc(1);
        chk_cnt("R4 first tick", 32'd1);
        wait_cyc(3);
        chk_cnt("R4 second tick", 32'd2);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_sup();
        setup(2, 100);
        wr(3'd1, 32'd0);
        wr(3'd0, C_SUP);
        wr(3'd5, 32'h1);
        chk("R5 strobe suppressed flag", 32'(upd_flag), 32'h0);
        wr(3'd0, C_SUP | C_RUN);
        wait_cyc(4);
        chk_cnt("R5 prescaler shadow kept", 32'd1);
        wr(3'd5, 32'h1);
        chk_cnt("R6 strobe clears counter", 32'd0);
        wait_cyc(2);
        chk_cnt("R6 prescaler count cleared", 32'd0);
        wait_cyc(1);
        chk_cnt("R6 tick after full period", 32'd1);
        setup(0, 2);
        wr(3'd0, C_SUP | C_RUN);
        wait_cyc(6);
        chk_cnt("R5 wraps while suppressed", 32'd0);
        chk("R5 overflow suppressed flag", 32'(upd_flag), 32'h0);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_src();
        setup(0, 100);
        wr(3'd5, 32'h1);
        chk("R7 strobe sets flag", 32'(upd_flag), 32'h1);
        wr(3'd4, 32'h0);
        wr(3'd0, C_OVO);
        wr(3'd5, 32'h1);
        chk("R7 strobe rejected", 32'(upd_flag), 32'h0);
        wr(3'd2, 32'd1);
        wr(3'd0, C_OVO | C_RUN);
        wait_cyc(2);
        chk("R7 overflow accepted", 32'(upd_flag), 32'h1);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_opm();
        logic [31:0] d;
        setup(0, 2);
        wr(3'd0, C_ONE | C_RUN);
        wait_cyc(3);
        rd(3'd0, d);
        chk("R8 run cleared", d, C_ONE);
        chk_cnt("R8 stopped at zero", 32'd0);
        wait_cyc(3);
        chk_cnt("R8 stays stopped", 32'd0);
    endtask

    task automatic t_buf();
        logic [31:0] d;
        setup(0, 5);
        wr(3'd0, C_BUF);
        wr(3'd2, 32'd2);
        rd(3'd2, d);
        chk("R9 reload readback", d, 32'd2);
        wr(3'd0, C_BUF | C_RUN);
        wait_cyc(3);
        chk_cnt("R9 old limit holds", 32'd3);
        wait_cyc(2);
        chk_cnt("R9 old limit top", 32'd5);
        wait_cyc(1);
        chk_cnt("R9 wrap at old limit", 32'd0);
        wr(3'd4, 32'h0);
        wait_cyc(1);
        chk_cnt("R9 new limit top", 32'd2);
        wait_cyc(1);
        chk_cnt("R9 wrap at new limit", 32'd0);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_div();
        int exp_n [4] = '{16, 8, 4, 16};
        for (int code = 0; code < 4; code++) begin
            int n = 0;
            wr(3'd0, 32'(code) << 5);
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (smp_en) n++;
            end
            chk("R10 sampling enable count", 32'(n), 32'(exp_n[code]));
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_mir();
        setup(0, 100);
        wr(3'd5, 32'h1);
        wr(3'd3, 32'd5);
        wr(3'd0, C_MIR);
        chk_cnt("R11 flag mirrored", 32'h8000_0005);
        wr(3'd0, 32'h0);
        chk_cnt("R11 mirror off", 32'h0000_0005);
        wr(3'd4, 32'h0);
        wr(3'd0, C_MIR);
        chk_cnt("R11 mirror with flag clear", 32'h0000_0005);
        wr(3'd0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_wrap();
        t_psc();
        t_sup();
        t_src();
        t_opm();
        t_buf();
        t_div();
        t_mir();
        finish_run();
    end

endmodule